// File: doc/BRIEF.md
# DMA Cycle-Stealing Budget Counter

This block does the cycle accounting for a processor core whose instruction stream can be stalled by DMA transfers. Software or a scheduler hands the block a run with a signed cycle budget. DMA engines post stall cycles at any time, and those cycles add up in a pending-stall counter. Before each instruction the block pays the pending stall out of the budget. If the budget cannot cover the whole stall, the block uses up the budget, leaves the remainder pending and ends the run with no instruction issued. If the budget can cover it, the block clears the stall, issues one instruction, and waits for the core to report that instruction's cost in cycles.

Each time cycles are consumed, the block adds them to a running total and announces the amount on a clock-sync output, so that peripherals advance by the same number of cycles. The run repeats while the budget is still positive. The last instruction may overshoot, which drives the budget negative. When the run ends, a done pulse reports the cycles the run actually used. The total counter and the pending-stall counter can both be read and loaded directly.

The run request is a valid/ready stream. `run_ready` is high only while no run is active, and a request held while busy waits without effect. The DMA, cost and sync paths carry no back-pressure: a DMA pulse is always taken, a cost report is taken only while an issued instruction is outstanding, and a sync pulse is one cycle wide and cannot be held off.

Top module: `dma_budget_counter`

## Requirements
- R1: Each cycle with `dma_valid` high adds `dma_cycles` to the pending-stall count. This also holds in the same cycle as a load or a consumption, in which case the add is applied on top of that result.
- R2: When the remaining budget is positive and less than or equal to the pending stall, the pending stall drops by the budget and the total rises by the budget. The run then ends with no instruction issued.
- R3: When the remaining budget is greater than the pending stall, the pending stall is cleared and subtracted from the budget, and `issue` pulses once. When the core then reports its cost, the stall plus the cost is added to the total and the cost is subtracted from the budget.
- R4: Every change of the total outside a direct load comes with a one-cycle `sync_valid` pulse, in the same cycle, whose `sync_cycles` equals the change.
- R5: The run loop continues while the budget is above zero. A run started with a budget of zero or less ends without consuming anything. A cost that overshoots leaves the budget negative and ends the run.
- R6: At the end of a run, `done` pulses for one cycle and `run_used` holds the total at the end minus the total when the run was accepted. `issue` and `done` are never high together.
- R7: After reset, the total and the pending stall are zero, `run_ready` is high, and `issue`, `done` and `sync_valid` are low.
- R8: `total_load` and `dma_load` replace their counters with the given value on the next edge. A load overrides any consumption in the same cycle.
- R9: A run request is accepted only on a cycle with both `run_valid` and `run_ready` high, and `run_ready` stays low until the run finishes. A cost report that arrives while no instruction is outstanding is ignored.
- R10: `issue` is a single-cycle pulse and does not repeat until the outstanding cost report has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_valid | input | 1 | Run request valid |
| run_ready | output | 1 | Block idle, ready to accept a run |
| run_budget | input | 32 | Signed cycle budget of the run |
| dma_valid | input | 1 | Add DMA stall cycles this cycle |
| dma_cycles | input | 32 | Stall cycles to add |
| cost_valid | input | 1 | Core reports cost of the issued instruction |
| cost_cycles | input | 32 | Cycles the instruction took |
| total_load | input | 1 | Load the total counter |
| total_load_val | input | 32 | Value for the total counter |
| dma_load | input | 1 | Load the pending-stall counter |
| dma_load_val | input | 32 | Value for the pending-stall counter |
| issue | output | 1 | One instruction may issue (pulse) |
| done | output | 1 | Run finished (pulse) |
| run_used | output | 32 | Cycles consumed by the last run |
| sync_valid | output | 1 | Cycles consumed this step (pulse) |
| sync_cycles | output | 32 | Number of cycles consumed |
| total_cnt | output | 32 | Running total of cycles |
| dma_cnt | output | 32 | Pending DMA stall cycles |

## Verification
The hardest state to reach from the ports is a stall posted while an instruction is outstanding. In that state the cost report and the DMA add land on the same edge, and the next step must then drain the new stall before it issues again. The bench's run task watches for the first `issue` pulse, then drives the cost and a DMA pulse together on that cycle. It also exercises the exact-equality boundary between budget and stall, and an overshoot that ends with a negative budget.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int CNT_W = 32;
  typedef logic signed [CNT_W-1:0] cnt_t;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } run_state_e;
endpackage

// File: rtl/dcb_acc.sv
module dcb_acc #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld,
  input  logic signed [W-1:0] ld_val,
  input  logic signed [W-1:0] fsm_delta,
  input  logic signed [W-1:0] ext_delta,
  output logic signed [W-1:0] q
);
  logic signed [W-1:0] base;

  // a direct load wins over the FSM's change; the external add stacks on top
  always_comb base = ld ? ld_val : (q + fsm_delta);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= base + ext_delta;
  end
endmodule

// File: rtl/dcb_ctrl.sv
module dcb_ctrl
  import dcb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_valid,
  output logic run_ready,
  input  cnt_t run_budget,
  input  logic cost_valid,
  input  cnt_t cost_cycles,
  input  cnt_t dma_q,
  input  cnt_t total_q,
  output cnt_t tot_delta,
  output cnt_t dma_delta,
  output logic issue,
  output logic done,
  output cnt_t run_used,
  output logic sync_valid,
  output cnt_t sync_cycles
);
  run_state_e st_q;
  cnt_t budget_q, start_q, step_q;
  logic check_short, check_over, cost_take;

  assign run_ready   = (st_q == ST_IDLE);
  assign check_over  = (st_q == ST_CHECK) && (budget_q <= 0);
  assign check_short = (st_q == ST_CHECK) && !check_over && (budget_q <= dma_q);
  assign cost_take   = (st_q == ST_WAIT) && cost_valid;

  always_comb begin
    tot_delta = '0;
    dma_delta = '0;
    if (check_short) begin
      tot_delta = budget_q;
      dma_delta = -budget_q;
    end else if ((st_q == ST_CHECK) && !check_over) begin
      dma_delta = -dma_q;
    end else if (cost_take) begin
      tot_delta = step_q + cost_cycles;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      budget_q    <= '0;
      start_q     <= '0;
      step_q      <= '0;
      issue       <= 1'b0;
      done        <= 1'b0;
      run_used    <= '0;
      sync_valid  <= 1'b0;
      sync_cycles <= '0;
    end else begin
      issue      <= 1'b0;
      done       <= 1'b0;
      sync_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (run_valid) begin
          budget_q <= run_budget;
          start_q  <= total_q;
          st_q     <= ST_CHECK;
        end
        ST_CHECK: begin
          if (check_over) begin
            st_q <= ST_FIN;
          end else if (check_short) begin
            sync_valid  <= 1'b1;
            sync_cycles <= budget_q;
            budget_q    <= '0;
            st_q        <= ST_FIN;
          end else begin
            step_q   <= dma_q;
            budget_q <= budget_q - dma_q;
            issue    <= 1'b1;
            st_q     <= ST_WAIT;
          end
        end
        ST_WAIT: if (cost_valid) begin
          sync_valid  <= 1'b1;
          sync_cycles <= step_q + cost_cycles;
          budget_q    <= budget_q - cost_cycles;
          st_q        <= ST_CHECK;
        end
        ST_FIN: begin
          done     <= 1'b1;
          run_used <= total_q - start_q;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_budget_counter.sv
module dma_budget_counter
  import dcb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_valid,
  output logic                    run_ready,
  input  logic signed [CNT_W-1:0] run_budget,
  input  logic                    dma_valid,
  input  logic signed [CNT_W-1:0] dma_cycles,
  input  logic                    cost_valid,
  input  logic signed [CNT_W-1:0] cost_cycles,
  input  logic                    total_load,
  input  logic signed [CNT_W-1:0] total_load_val,
  input  logic                    dma_load,
  input  logic signed [CNT_W-1:0] dma_load_val,
  output logic                    issue,
  output logic                    done,
  output logic signed [CNT_W-1:0] run_used,
  output logic                    sync_valid,
  output logic signed [CNT_W-1:0] sync_cycles,
  output logic signed [CNT_W-1:0] total_cnt,
  output logic signed [CNT_W-1:0] dma_cnt
);
  cnt_t tot_delta, dma_delta, dma_add;

  assign dma_add = dma_valid ? dma_cycles : '0;

  dcb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .run_valid(run_valid), .run_ready(run_ready), .run_budget(run_budget),
    .cost_valid(cost_valid), .cost_cycles(cost_cycles),
    .dma_q(dma_cnt), .total_q(total_cnt),
    .tot_delta(tot_delta), .dma_delta(dma_delta),
    .issue(issue), .done(done), .run_used(run_used),
    .sync_valid(sync_valid), .sync_cycles(sync_cycles)
  );

  dcb_acc #(.W(CNT_W)) u_total (
    .clk(clk), .rst_n(rst_n),
    .ld(total_load), .ld_val(total_load_val),
    .fsm_delta(tot_delta), .ext_delta('0),
    .q(total_cnt)
  );

  dcb_acc #(.W(CNT_W)) u_dma (
    .clk(clk), .rst_n(rst_n),
    .ld(dma_load), .ld_val(dma_load_val),
    .fsm_delta(dma_delta), .ext_delta(dma_add),
    .q(dma_cnt)
  );
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker (
  input logic               clk,
  input logic               rst_n,
  input logic               run_valid,
  input logic               run_ready,
  input logic               dma_valid,
  input logic signed [31:0] dma_cycles,
  input logic               dma_load,
  input logic               total_load,
  input logic               issue,
  input logic               done,
  input logic               sync_valid,
  input logic signed [31:0] sync_cycles,
  input logic signed [31:0] total_cnt,
  input logic signed [31:0] dma_cnt
);
  assert_issue_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);

  assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && issue));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && run_ready) |=> !run_ready);

  assert_dma_add_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ready && dma_valid && !dma_load) |=> (dma_cnt == $past(dma_cnt) + $past(dma_cycles)));

  assert_total_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !total_load |=> (total_cnt == $past(total_cnt) + (sync_valid ? sync_cycles : 32'sd0)));
endmodule

bind dma_budget_counter dcb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run_valid(run_valid), .run_ready(run_ready),
  .dma_valid(dma_valid), .dma_cycles(dma_cycles), .dma_load(dma_load),
  .total_load(total_load), .issue(issue), .done(done),
  .sync_valid(sync_valid), .sync_cycles(sync_cycles),
  .total_cnt(total_cnt), .dma_cnt(dma_cnt)
);

// File: tb/tb_dma_budget_counter.sv
module tb_dma_budget_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_valid = 1'b0, dma_valid = 1'b0, cost_valid = 1'b0;
  logic total_load = 1'b0, dma_load = 1'b0;
  logic signed [31:0] run_budget = '0, dma_cycles = '0, cost_cycles = '0;
  logic signed [31:0] total_load_val = '0, dma_load_val = '0;
  logic run_ready, issue, done, sync_valid;
  logic signed [31:0] run_used, sync_cycles, total_cnt, dma_cnt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_budget_counter dut (
    .clk(clk), .rst_n(rst_n),
    .run_valid(run_valid), .run_ready(run_ready), .run_budget(run_budget),
    .dma_valid(dma_valid), .dma_cycles(dma_cycles),
    .cost_valid(cost_valid), .cost_cycles(cost_cycles),
    .total_load(total_load), .total_load_val(total_load_val),
    .dma_load(dma_load), .dma_load_val(dma_load_val),
    .issue(issue), .done(done), .run_used(run_used),
    .sync_valid(sync_valid), .sync_cycles(sync_cycles),
    .total_cnt(total_cnt), .dma_cnt(dma_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(input int idx, input int c0, input int c1, input int c2);
    if (idx == 0) return c0;
    if (idx == 1) return c1;
    return c2;
  endfunction

  // starts a run, plays the core, optionally posts DMA on the first issue
  task automatic do_run(input int budget, input int c0, input int c1, input int c2,
                        input int inject, output int n_issue, output int used,
                        output int ssum, output int ready_after);
    int idx = 0;
    n_issue = 0; ssum = 0; used = -1;
    @(negedge clk);
    run_valid = 1'b1; run_budget = budget;
    @(negedge clk);
    run_valid = 1'b0;
    ready_after = int'(run_ready);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      cost_valid = 1'b0; dma_valid = 1'b0;
      if (sync_valid) ssum += sync_cycles;
      if (done) begin used = run_used; break; end
      if (issue) begin
        cost_valid  = 1'b1;
        cost_cycles = pick(idx, c0, c1, c2);
        if (idx == 0 && inject != 0) begin
          dma_valid = 1'b1; dma_cycles = inject;
        end
        idx++;
        n_issue++;
      end
    end
  endtask

  task automatic t_reset;
    chk("R7 total", total_cnt, 0);
    chk("R7 dma", dma_cnt, 0);
    chk("R7 ready", int'(run_ready), 1);
    chk("R7 pulses", int'(issue) + int'(done) + int'(sync_valid), 0);
  endtask

  task automatic t_dma_accum;
    @(negedge clk); dma_valid = 1'b1; dma_cycles = 5;
    @(negedge clk); dma_cycles = 7;
    @(negedge clk); dma_valid = 1'b0;
    chk("R1 accumulate", dma_cnt, 12);
  endtask

  task automatic t_partial;
    int ni, u, s, r;
    do_run(5, 1, 1, 1, 0, ni, u, s, r);
    chk("R9 busy ready", r, 0);
    chk("R2 no issue", ni, 0);
    chk("R2 dma left", dma_cnt, 7);
    chk("R2 total", total_cnt, 5);
    chk("R4 sync", s, 5);
    chk("R6 used", u, 5);
  endtask

  task automatic t_equal;
    int ni, u, s, r;
    do_run(7, 1, 1, 1, 0, ni, u, s, r);
    chk("R2 equal no issue", ni, 0);
    chk("R2 equal dma", dma_cnt, 0);
    chk("R2 equal total", total_cnt, 12);
  endtask

  task automatic t_drain_issue;
    int ni, u, s, r;
    @(negedge clk); dma_load = 1'b1; dma_load_val = 3;
    @(negedge clk); dma_load = 1'b0;
    chk("R8 dma load", dma_cnt, 3);
    do_run(10, 4, 5, 5, 0, ni, u, s, r);
    chk("R3 issues", ni, 2);
    chk("R5 overshoot used", u, 12);
    chk("R4 sync sum", s, 12);
    chk("R3 dma cleared", dma_cnt, 0);
    chk("R3 total", total_cnt, 24);
  endtask

  task automatic t_zero_budget;
    int ni, u, s, r;
    do_run(0, 1, 1, 1, 0, ni, u, s, r);
    chk("R5 zero issues", ni, 0);
    chk("R5 zero used", u, 0);
    chk("R5 zero total", total_cnt, 24);
  endtask

  task automatic t_inject;
    int ni, u, s, r;
    do_run(20, 2, 3, 10, 6, ni, u, s, r);
    chk("R1 inject issues", ni, 3);
    chk("R3 inject used", u, 21);
    chk("R1 inject dma", dma_cnt, 0);
    chk("R3 inject total", total_cnt, 45);
  endtask

  task automatic t_cost_ignored;
    int seen = 0;
    @(negedge clk); cost_valid = 1'b1; cost_cycles = 99;
    @(negedge clk); cost_valid = 1'b0;
    if (sync_valid) seen = 1;
    @(negedge clk);
    chk("R9 cost ignored total", total_cnt, 45);
    chk("R9 cost ignored sync", seen, 0);
  endtask

  task automatic t_loads;
    int ni, u, s, r;
    @(negedge clk);
    total_load = 1'b1; total_load_val = 1000;
    dma_load = 1'b1; dma_load_val = 50; dma_valid = 1'b1; dma_cycles = 4;
    @(negedge clk);
    total_load = 1'b0; dma_load = 1'b0; dma_valid = 1'b0;
    chk("R8 total load", total_cnt, 1000);
    chk("R8 load plus add", dma_cnt, 54);
    do_run(20, 1, 1, 1, 0, ni, u, s, r);
    chk("R2 after load dma", dma_cnt, 34);
    chk("R6 after load used", u, 20);
    chk("R2 after load total", total_cnt, 1020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_dma_accum;
    t_partial;
    t_equal;
    t_drain_issue;
    t_zero_budget;
    t_inject;
    t_cost_ignored;
    t_loads;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule